// File: doc/BRIEF.md
# Clock Synthesizer Configuration Sequencer

This block is the control sequencer of a programmable clock synthesizer. When power-on reset is released it walks a nonvolatile fuse array and copies its contents, one control word followed by four frequency words, into a working shadow set. Only after that copy does it inspect a two-bit lock field. One lock setting sends it through an initial calibration into normal operation. The other settings park it in a command-wait mode, where a crystal-pattern field may hold it in a tuning state.

In normal operation the block owns the current frequency word. A frequency update arriving on the register write port is sorted against a precomputed threshold word. A small step is applied at once, with the output left running. A large step, or any settled change on the two select pins, starts an external calibration and blanks the output until the calibration reports done. When the shadow configuration selects integer-mode PLL operation, small steps are refused. The output enable follows a pin whose active level comes from a configuration bit.

States: `ST_COPY` (fuse walk) → `ST_DECODE` (lock decode) → `ST_CAL` (lock 01/10) or `ST_CMDWAIT` (lock 00/11). `ST_CMDWAIT` → `ST_TUNE` when the crystal pattern is 01/10. `ST_TUNE` → `ST_CMDWAIT` when a control write clears that pattern. `ST_CMDWAIT` → `ST_CAL` on the exit command. `ST_CAL` → `ST_ACTIVE` on `cal_done`. `ST_ACTIVE` → `ST_CAL` on a select change or a large update. `ST_ACTIVE` stays in place on a small or rejected update.

Top module: `clkcfg_seq`

## Requirements
- R1: After reset release the fuse address visits words 0..4 once. Word 0 is the control word. Its bits are [1:0] lock, [3:2] crystal pattern, [4] OE polarity and [5] integer mode. Words 1..4 are frequency settings 0..3. No calibration start and no valid output appear before the copy ends.
- R2: A lock field of 01 or 10 starts a calibration right after decode. `clk_valid` rises only in the cycle after `cal_done` is seen.
- R3: A lock field of 00 or 11 enters command-wait with `clk_valid` low and no calibration. A write with `wr_op`=01 (exit) there starts calibration, and the block becomes valid once the calibration is done.
- R4: In command-wait a crystal pattern of 01 or 10 raises `xtal_tune`, and a pattern of 00 or 11 does not. A write with `wr_op`=10 loads `wr_data[5:0]` into the control field. This write is accepted only in command-wait or tuning, and it returns tuning to command-wait when the new pattern is 00 or 11.
- R5: In active state a write with `wr_op`=00 whose absolute difference from `freq_word` is at most `SMALL_LIMIT` is a small change. It loads `freq_word`, pulses `small_ack`, keeps `clk_valid` high and starts no calibration.
- R6: A frequency update whose difference exceeds `SMALL_LIMIT` loads `freq_word` and pulses `cal_start`. `clk_valid` is low from that cycle until the cycle after `cal_done`.
- R7: With integer mode set, a small update is refused. `chg_reject` pulses, `freq_word` holds and `clk_valid` stays high. Large updates are still accepted.
- R8: Select code 00, 01, 10 or 11 picks setting 0, 1, 2 or 3. A settled change of the select code in active state loads that setting and recalibrates, as for a large change.
- R9: `out_en` is high only when `clk_valid` is high and `oe_pin` equals the polarity bit (0 means active-low, the reset default of the shadow).
- R10: The select pins pass a two-flop synchronizer and act only after two equal consecutive samples, so a one-cycle pulse on them has no effect.
- R11: Frequency writes outside active state (during calibration or command-wait) leave `freq_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| fuse_addr | output | 3 | Fuse word address during the copy |
| fuse_rdata | input | FW | Fuse word at `fuse_addr` (same-cycle read) |
| wr_stb | input | 1 | Register write strobe |
| wr_op | input | 2 | 00 frequency, 01 exit, 10 control, 11 none |
| wr_data | input | FW | Write payload |
| sel_pins | input | 2 | Frequency select pins (asynchronous) |
| oe_pin | input | 1 | Output-enable pin |
| cal_done | input | 1 | Calibration finished |
| cal_start | output | 1 | One-cycle calibration start |
| clk_valid | output | 1 | Output clock stable |
| out_en | output | 1 | Output driver enable |
| freq_word | output | FW | Frequency word in force |
| small_ack | output | 1 | Small change applied |
| chg_reject | output | 1 | Small change refused (integer mode) |
| xtal_tune | output | 1 | Crystal tuning state |

## Verification
A wrong state register shows up first on `clk_valid` and `cal_start`. A mis-sorted update either blanks the output in the cycle after the write when it should not, or leaves the output valid with no start pulse. Both are visible one edge after the strobe. A wrong shadow copy or select mapping shows up as a wrong `freq_word` once the settle window of about four cycles plus the calibration has passed. A stuck mode decode keeps `clk_valid` low or `xtal_tune` high well beyond the point where the boot should have finished.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        ST_COPY    = 3'd0,
        ST_DECODE  = 3'd1,
        ST_CMDWAIT = 3'd2,
        ST_TUNE    = 3'd3,
        ST_CAL     = 3'd4,
        ST_ACTIVE  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_FREQ = 2'b00,
        OP_EXIT = 2'b01,
        OP_CTRL = 2'b10,
        OP_NONE = 2'b11
    } wr_op_e;

    localparam int CTRL_W     = 6;
    localparam int LOCK_LSB   = 0;
    localparam int XPAT_LSB   = 2;
    localparam int OEPOL_BIT  = 4;
    localparam int INTMODE_BIT = 5;

    // True for the two "mixed" codes 01 and 10
    function automatic logic is_mixed(input logic [1:0] code);
        return code[1] ^ code[0];
    endfunction

endpackage

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow #(
    parameter int FW   = 16,
    parameter int NSET = 4,
    localparam int NW  = NSET + 1,
    localparam int AW  = $clog2(NW)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [AW-1:0]             fuse_addr,
    input  logic [FW-1:0]             fuse_rdata,
    input  logic                      ctrl_we,
    input  logic [clkcfg_pkg::CTRL_W-1:0] ctrl_wdata,
    output logic                      copy_done,
    output logic [clkcfg_pkg::CTRL_W-1:0] ctrl,
    output logic [NSET-1:0][FW-1:0]   set_words
);
    localparam logic [AW-1:0] LAST = AW'(NW - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            copy_done <= 1'b0;
            ctrl      <= '0;
            set_words <= '0;
        end else if (!copy_done) begin
            if (addr_q == '0) begin
                ctrl <= fuse_rdata[clkcfg_pkg::CTRL_W-1:0];
            end
            for (int i = 0; i < NSET; i++) begin
                if (addr_q == AW'(i + 1)) begin
                    set_words[i] <= fuse_rdata;
                end
            end
            if (addr_q == LAST) begin
                copy_done <= 1'b1;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end else if (ctrl_we) begin
            ctrl <= ctrl_wdata;
        end
    end

    assign fuse_addr = addr_q;

endmodule

// File: rtl/clkcfg_selsync.sv
module clkcfg_selsync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sel_stable
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q     <= '0;
            sync_q     <= '0;
            prev_q     <= '0;
            sel_stable <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (sync_q == prev_q) begin
                sel_stable <= sync_q;
            end
        end
    end

endmodule

// File: rtl/clkcfg_classify.sv
module clkcfg_classify #(
    parameter int FW          = 16,
    parameter int SMALL_LIMIT = 40
) (
    input  logic [FW-1:0] cur_word,
    input  logic [FW-1:0] new_word,
    output logic          is_small
);
    logic [FW-1:0] delta;

    // Subtract the smaller from the larger so the result never wraps
    always_comb begin
        if (new_word >= cur_word) begin
            delta = new_word - cur_word;
        end else begin
            delta = cur_word - new_word;
        end
        is_small = ({1'b0, delta} <= (FW+1)'(SMALL_LIMIT));
    end

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq #(
    parameter int FW          = 16,
    parameter int SMALL_LIMIT = 40,
    localparam int NSET       = 4,
    localparam int SW         = $clog2(NSET),
    localparam int AW         = $clog2(NSET + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] fuse_addr,
    input  logic [FW-1:0] fuse_rdata,
    input  logic          wr_stb,
    input  logic [1:0]    wr_op,
    input  logic [FW-1:0] wr_data,
    input  logic [SW-1:0] sel_pins,
    input  logic          oe_pin,
    input  logic          cal_done,
    output logic          cal_start,
    output logic          clk_valid,
    output logic          out_en,
    output logic [FW-1:0] freq_word,
    output logic          small_ack,
    output logic          chg_reject,
    output logic          xtal_tune
);
    import clkcfg_pkg::*;

    seq_state_e state, next_state;

    logic                   copy_done;
    logic [CTRL_W-1:0]      ctrl;
    logic [NSET-1:0][FW-1:0] set_words;
    logic [SW-1:0]          sel_stable, sel_cur;
    logic                   is_small;
    logic                   ctrl_we;

    logic [1:0] lock_f, xpat_f;
    logic       oe_pol, int_mode;
    logic       sel_chg, freq_wr, small_ok, small_bad, large_wr, exit_cmd;

    clkcfg_shadow #(.FW(FW), .NSET(NSET)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .fuse_addr  (fuse_addr),
        .fuse_rdata (fuse_rdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (wr_data[CTRL_W-1:0]),
        .copy_done  (copy_done),
        .ctrl       (ctrl),
        .set_words  (set_words)
    );

    clkcfg_selsync #(.W(SW)) u_selsync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (sel_pins),
        .sel_stable (sel_stable)
    );

    clkcfg_classify #(.FW(FW), .SMALL_LIMIT(SMALL_LIMIT)) u_classify (
        .cur_word (freq_word),
        .new_word (wr_data),
        .is_small (is_small)
    );

    assign lock_f   = ctrl[LOCK_LSB +: 2];
    assign xpat_f   = ctrl[XPAT_LSB +: 2];
    assign oe_pol   = ctrl[OEPOL_BIT];
    assign int_mode = ctrl[INTMODE_BIT];

    // Event decode
    always_comb begin
        ctrl_we   = wr_stb && (wr_op == OP_CTRL) &&
                    ((state == ST_CMDWAIT) || (state == ST_TUNE));
        exit_cmd  = wr_stb && (wr_op == OP_EXIT) && (state == ST_CMDWAIT);
        sel_chg   = (state == ST_ACTIVE) && (sel_stable != sel_cur);
        freq_wr   = (state == ST_ACTIVE) && wr_stb && (wr_op == OP_FREQ) && !sel_chg;
        small_ok  = freq_wr && is_small && !int_mode;
        small_bad = freq_wr && is_small && int_mode;
        large_wr  = freq_wr && !is_small;
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_COPY:    if (copy_done) next_state = ST_DECODE;
            ST_DECODE:  next_state = is_mixed(lock_f) ? ST_CAL : ST_CMDWAIT;
            ST_CMDWAIT: begin
                if (is_mixed(xpat_f))  next_state = ST_TUNE;
                else if (exit_cmd)     next_state = ST_CAL;
            end
            ST_TUNE:    if (!is_mixed(xpat_f)) next_state = ST_CMDWAIT;
            ST_CAL:     if (cal_done) next_state = ST_ACTIVE;
            ST_ACTIVE:  if (sel_chg || large_wr) next_state = ST_CAL;
            default:    next_state = ST_COPY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COPY;
        else        state <= next_state;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_start  <= 1'b0;
            clk_valid  <= 1'b0;
            xtal_tune  <= 1'b0;
            small_ack  <= 1'b0;
            chg_reject <= 1'b0;
            freq_word  <= '0;
            sel_cur    <= '0;
        end else begin
            cal_start  <= (next_state == ST_CAL) && (state != ST_CAL);
            clk_valid  <= (next_state == ST_ACTIVE);
            xtal_tune  <= (next_state == ST_TUNE);
            small_ack  <= small_ok;
            chg_reject <= small_bad;
            if ((state == ST_DECODE) || sel_chg) begin
                freq_word <= set_words[sel_stable];
                sel_cur   <= sel_stable;
            end else if (small_ok || large_wr) begin
                freq_word <= wr_data;
            end
        end
    end

    assign out_en = clk_valid && (oe_pin == oe_pol);

endmodule

// File: rtl/clkcfg_seq_chk.sv
module clkcfg_seq_chk #(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cal_start,
    input logic          cal_done,
    input logic          clk_valid,
    input logic          out_en,
    input logic [FW-1:0] freq_word,
    input logic          small_ack,
    input logic          chg_reject,
    input logic          xtal_tune
);
    assert_valid_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_valid) |-> $past(cal_done));

    assert_tune_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_tune |-> !clk_valid);

    assert_small_keeps_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        small_ack |-> (clk_valid && !cal_start));

    assert_start_blanks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> !clk_valid);

    assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_start, small_ack, chg_reject}));

    assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_reject |-> ($stable(freq_word) && clk_valid));

    assert_oe_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> clk_valid);

endmodule

bind clkcfg_seq clkcfg_seq_chk #(.FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_start  (cal_start),
    .cal_done   (cal_done),
    .clk_valid  (clk_valid),
    .out_en     (out_en),
    .freq_word  (freq_word),
    .small_ack  (small_ack),
    .chg_reject (chg_reject),
    .xtal_tune  (xtal_tune)
);

// File: tb/clkcfg_seq_bench.sv
module clkcfg_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    fuse_addr;
    logic [FW-1:0] fuse_rdata;
    logic          wr_stb = 1'b0;
    logic [1:0]    wr_op = 2'b11;
    logic [FW-1:0] wr_data = '0;
    logic [1:0]    sel_pins = 2'b00;
    logic          oe_pin = 1'b0;
    logic          cal_done = 1'b0;
    logic          cal_start, clk_valid, out_en, small_ack, chg_reject, xtal_tune;
    logic [FW-1:0] freq_word;

    logic [FW-1:0] fuse_ctrl = '0;
    int            total = 0;
    int            bad = 0;
    int            cal_cnt = 0;
    int            pend = 0;
    logic [4:0]    addr_seen = '0;
    bit            finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Fuse array model: word 0 control, words 1..4 = 0x1000 * index
    assign fuse_rdata = (fuse_addr == 3'd0) ? fuse_ctrl : (16'(fuse_addr) << 12);

    clkcfg_seq #(.FW(FW), .SMALL_LIMIT(40)) u_clkcfg_seq (
        .clk(clk), .rst_n(rst_n), .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata),
        .wr_stb(wr_stb), .wr_op(wr_op), .wr_data(wr_data), .sel_pins(sel_pins),
        .oe_pin(oe_pin), .cal_done(cal_done), .cal_start(cal_start),
        .clk_valid(clk_valid), .out_en(out_en), .freq_word(freq_word),
        .small_ack(small_ack), .chg_reject(chg_reject), .xtal_tune(xtal_tune)
    );

    // Calibration responder: done four cycles after each start
    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 0;
            cal_done = 1'b0;
        end else begin
            cal_done = 1'b0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) cal_done = 1'b1;
            end
            if (cal_start) begin
                cal_cnt = cal_cnt + 1;
                pend = 4;
            end
            if (fuse_addr < 3'd5) addr_seen[fuse_addr] = 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] op, input logic [FW-1:0] data);
        wr_stb = 1'b1; wr_op = op; wr_data = data;
        tick(1);
        wr_stb = 1'b0; wr_op = 2'b11;
    endtask

    task automatic boot(input logic [FW-1:0] ctrl);
        int base;
        rst_n = 1'b0; fuse_ctrl = ctrl; sel_pins = 2'b00;
        tick(3);
        rst_n = 1'b1;
        base = cal_cnt;
        tick(4);
        check("R1 no start during copy", 32'(cal_cnt - base), 0);
        check("R1 not valid during copy", {31'b0, clk_valid}, 0);
        tick(30);
    endtask

    // {expect_small, new frequency word}, applied in order from 0x1000
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 16'h1028}, {1'b0, 16'h1051}, {1'b1, 16'h1029}, {1'b0, 16'h1000},
        {1'b0, 16'hFFFF}, {1'b1, 16'hFFD7}, {1'b0, 16'h0000}, {1'b1, 16'h0000}
    };

    initial begin
        int base;
        // Reset state
        tick(2);
        check("R1 reset clk_valid", {31'b0, clk_valid}, 0);
        check("R1 reset cal_start", {31'b0, cal_start}, 0);
        check("R9 reset out_en", {31'b0, out_en}, 0);
        check("R1 reset fuse_addr", {29'b0, fuse_addr}, 0);

        // Lock 01, OE active-low, fractional mode
        base = cal_cnt;
        boot(16'h0001);
        check("R1 all fuse words read", {27'b0, addr_seen}, 32'h1F);
        check("R2 valid after boot", {31'b0, clk_valid}, 1);
        check("R2 one calibration", 32'(cal_cnt - base), 1);
        check("R8 setting0 loaded", {16'b0, freq_word}, 32'h1000);

        // Vector walk: small and large updates
        for (int i = 0; i < 8; i++) begin
            base = cal_cnt;
            do_write(2'b00, VEC[i][15:0]);
            if (VEC[i][16]) begin
                check("R5 small keeps valid", {31'b0, clk_valid}, 1);
                check("R5 small_ack pulse", {31'b0, small_ack}, 1);
            end else begin
                check("R6 large blanks", {31'b0, clk_valid}, 0);
            end
            tick(12);
            check("R5 R6 freq word", {16'b0, freq_word}, {16'b0, VEC[i][15:0]});
            check("R6 calibration count", 32'(cal_cnt - base), VEC[i][16] ? 0 : 1);
            check("R6 valid again", {31'b0, clk_valid}, 1);
        end

        // R11: write during calibration is ignored
        do_write(2'b00, 16'h5000);
        tick(1);
        do_write(2'b00, 16'h5010);
        tick(12);
        check("R11 write in CAL ignored", {16'b0, freq_word}, 32'h5000);

        // R9: active-low OE
        oe_pin = 1'b0; tick(1);
        check("R9 low-active enabled", {31'b0, out_en}, 1);
        oe_pin = 1'b1; tick(1);
        check("R9 low-active disabled", {31'b0, out_en}, 0);

        // R8: select changes
        base = cal_cnt;
        sel_pins = 2'b10; tick(20);
        check("R8 code 10 -> setting2", {16'b0, freq_word}, 32'h3000);
        check("R8 recalibrated", 32'(cal_cnt - base), 1);
        sel_pins = 2'b11; tick(20);
        check("R8 code 11 -> setting3", {16'b0, freq_word}, 32'h4000);
        sel_pins = 2'b01; tick(20);
        check("R8 code 01 -> setting1", {16'b0, freq_word}, 32'h2000);

        // R10: one-cycle glitch ignored
        base = cal_cnt;
        sel_pins = 2'b00; tick(1); sel_pins = 2'b01;
        tick(20);
        check("R10 glitch freq", {16'b0, freq_word}, 32'h2000);
        check("R10 glitch no cal", 32'(cal_cnt - base), 0);

        // R7: integer mode, lock 10, OE active-high
        boot(16'h0032);
        check("R7 boot valid", {31'b0, clk_valid}, 1);
        oe_pin = 1'b1; tick(1);
        check("R9 high-active enabled", {31'b0, out_en}, 1);
        oe_pin = 1'b0; tick(1);
        check("R9 high-active disabled", {31'b0, out_en}, 0);
        do_write(2'b00, 16'h1010);
        check("R7 reject pulse", {31'b0, chg_reject}, 1);
        check("R7 still valid", {31'b0, clk_valid}, 1);
        tick(5);
        check("R7 freq held", {16'b0, freq_word}, 32'h1000);
        do_write(2'b00, 16'h2000);
        tick(12);
        check("R7 large accepted", {16'b0, freq_word}, 32'h2000);

        // R3: lock 00 -> command-wait, exit
        base = cal_cnt;
        boot(16'h0000);
        check("R3 cmdwait not valid", {31'b0, clk_valid}, 0);
        check("R3 no calibration", 32'(cal_cnt - base), 0);
        check("R4 pattern 00 no tune", {31'b0, xtal_tune}, 0);
        do_write(2'b00, 16'h1010);
        do_write(2'b01, 16'h0000);
        tick(12);
        check("R3 exit -> valid", {31'b0, clk_valid}, 1);
        check("R11 cmdwait write ignored", {16'b0, freq_word}, 32'h1000);

        // R3: lock 11 also waits
        boot(16'h0003);
        check("R3 lock 11 waits", {31'b0, clk_valid}, 0);

        // R4: crystal tuning
        boot(16'h0004);
        check("R4 pattern 01 tunes", {31'b0, xtal_tune}, 1);
        do_write(2'b01, 16'h0000);
        tick(12);
        check("R4 exit ignored in tune", {31'b0, clk_valid}, 0);
        do_write(2'b10, 16'h000C);
        tick(3);
        check("R4 pattern 11 leaves tune", {31'b0, xtal_tune}, 0);
        boot(16'h0008);
        check("R4 pattern 10 tunes", {31'b0, xtal_tune}, 1);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule